// File: doc/BRIEF.md
# UART Xon/Xoff Software Flow Controller

This block sits between a UART receiver and the receive FIFO, and beside the UART transmitter, to carry out in-band software flow control. Each received byte is tested against programmed stop and resume codes, one byte per code or a two-byte sequence per code. A stop code sets a stop-detected flag, which can raise an interrupt. It also asks the local transmitter to pause once the character it is shifting out has finished. A resume code clears the flag and lifts the pause. Bytes consumed as codes never reach the receive FIFO. All other bytes are forwarded in arrival order.

In the other direction, the block watches the local receive FIFO fill level against a trigger level. When the fill rises above the trigger, the block asks the transmitter to insert the stop code into the outgoing stream. When the fill falls back below the trigger, it asks for the resume code. Each code byte is offered on a request/acknowledge port until the transmitter takes it. Received-byte strobes are expected at least three clock cycles apart, which any serial bit rate gives with a wide margin.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: Four code registers reset to zero and are written when `cfg_we` is high. The address selects the register: 0 is stop first byte, 1 is stop second byte, 2 is resume first byte, 3 is resume second byte. `cfg_rdata` returns the register selected by `cfg_addr` in the same cycle.
- R2: `fc_mode` encodes 0 as off, 1 as single-byte codes, and 2 or 3 as two-byte codes. In single mode, a received byte equal to the stop first byte is a stop detection.
- R3: In two-byte mode, a stop detection needs two consecutive bytes equal to the stop first byte and then the stop second byte. A resume detection needs the resume first byte and then the resume second byte.
- R4: A byte that is not consumed as part of a detected code is written to the FIFO port. The write happens in the cycle after its strobe, and bytes keep their arrival order. Bytes that complete or form a detected code are never written.
- R5: In two-byte mode, a held first byte whose successor does not complete its code is written one cycle after the successor arrives. The successor is then tested as a new first byte. If it is not a first byte, it is written one cycle later.
- R6: `xoff_det` rises the cycle after a stop detection and falls the cycle after a resume detection. `xoff_irq` is high exactly while `xoff_det` and `xoff_irq_en` are both high.
- R7: `tx_halt` takes the value of `xoff_det` on each clock edge where `tx_busy` is low. It holds its value while `tx_busy` is high, so a character in flight always finishes.
- R8: When the FIFO level goes above the trigger, the stop code is offered on `ins_req`/`ins_char` from the next cycle. When the level later goes below the trigger, the resume code is offered. A level equal to the trigger changes nothing. A level that stays on one side produces no further request.
- R9: Each offered code byte is held on `ins_char` with `ins_req` high until `ins_ack`. In two-byte mode, the first byte is offered and then the second. In single mode, only the first byte is offered.
- R10: Mode 0 forwards every received byte and clears `xoff_det` and `tx_halt` on the next edge. It also withdraws any pending insertion request.
- R11: Resume codes are only tested while `xoff_det` is high, and then they take precedence over the stop code. At other times a resume byte is forwarded as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Code register write strobe |
| cfg_addr | input | 2 | Code register select |
| cfg_wdata | input | CHAR_W | Code register write data |
| cfg_rdata | output | CHAR_W | Selected code register value |
| fc_mode | input | 2 | Flow control mode |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | CHAR_W | Received byte |
| fifo_wr_en | output | 1 | Receive FIFO write strobe |
| fifo_wr_data | output | CHAR_W | Receive FIFO write data |
| fifo_level | input | LVL_W | Current receive FIFO fill |
| fifo_trig | input | LVL_W | Receive FIFO trigger level |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_halt | output | 1 | Transmitter must not start a data character |
| ins_req | output | 1 | Code byte insertion request |
| ins_char | output | CHAR_W | Code byte to insert |
| ins_ack | input | 1 | Transmitter accepted the code byte |
| xoff_irq_en | input | 1 | Stop-detected interrupt enable |
| xoff_det | output | 1 | Stop-detected flag |
| xoff_irq | output | 1 | Stop-detected interrupt |

## Verification
A forwarded byte is due one cycle after its strobe. The held first byte and the retested successor of a broken two-byte pair are due one and two cycles after the successor. The bench drives each byte at a falling edge and then waits four falling edges before it compares the captured FIFO writes with the model's list, so every write lands inside the window. `xoff_det` is checked in that same window. `tx_halt` is checked one edge after `tx_busy` falls, and the insertion port is checked at the first falling edge after a level change or an acknowledge.

// File: rtl/xf_pkg.sv
package xf_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_ONE  = 2'd1,
        MODE_TWO  = 2'd2,
        MODE_TWO2 = 2'd3
    } fc_mode_e;

    typedef enum logic [1:0] {
        INS_IDLE   = 2'd0,
        INS_FIRST  = 2'd1,
        INS_SECOND = 2'd2
    } ins_state_e;

    localparam int NUM_CODE_REGS = 4;
    localparam int SEL_OFF_A     = 0;
    localparam int SEL_OFF_B     = 1;
    localparam int SEL_ON_A      = 2;
    localparam int SEL_ON_B      = 3;

    function automatic logic mode_is_pair(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/xf_code_regs.sv
module xf_code_regs
    import xf_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [CHAR_W-1:0] wdata,
    output logic [CHAR_W-1:0] rdata,
    output logic [CHAR_W-1:0] off_a,
    output logic [CHAR_W-1:0] off_b,
    output logic [CHAR_W-1:0] on_a,
    output logic [CHAR_W-1:0] on_b
);

    logic [NUM_CODE_REGS-1:0][CHAR_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_CODE_REGS; i++) begin
            if (we && (addr == i[1:0])) begin
                regs_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata = regs_q[addr];
    assign off_a = regs_q[SEL_OFF_A];
    assign off_b = regs_q[SEL_OFF_B];
    assign on_a  = regs_q[SEL_ON_A];
    assign on_b  = regs_q[SEL_ON_B];

endmodule

// File: rtl/xf_rx_match.sv
module xf_rx_match
    import xf_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic [CHAR_W-1:0] off_a,
    input  logic [CHAR_W-1:0] off_b,
    input  logic [CHAR_W-1:0] on_a,
    input  logic [CHAR_W-1:0] on_b,
    output logic              wr_en,
    output logic [CHAR_W-1:0] wr_data,
    output logic              det
);

    typedef struct packed {
        logic              det;
        logic              held_v;
        logic              held_off;
        logic              held_on;
        logic [CHAR_W-1:0] held;
        logic              pend_v;
        logic [CHAR_W-1:0] pend;
        logic              wr_en;
        logic [CHAR_W-1:0] wr_data;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic      first_off;
    logic      first_on;

    // A byte may open a code; resume codes only count while stopped.
    assign first_off = (rx_data == off_a);
    assign first_on  = s_q.det && (rx_data == on_a);

    always_comb begin
        s_d       = s_q;
        s_d.wr_en = 1'b0;

        if (s_q.pend_v) begin
            s_d.wr_en   = 1'b1;
            s_d.wr_data = s_q.pend;
            s_d.pend_v  = 1'b0;
        end

        if (mode == MODE_OFF) begin
            s_d.det    = 1'b0;
            s_d.held_v = 1'b0;
            s_d.pend_v = 1'b0;
            if (rx_valid) begin
                s_d.wr_en   = 1'b1;
                s_d.wr_data = rx_data;
            end
        end else if (rx_valid) begin
            if (!mode_is_pair(mode)) begin
                s_d.held_v = 1'b0;
                if (first_on) begin
                    s_d.det = 1'b0;
                end else if (first_off) begin
                    s_d.det = 1'b1;
                end else begin
                    s_d.wr_en   = 1'b1;
                    s_d.wr_data = rx_data;
                end
            end else if (s_q.held_v) begin
                if (s_q.held_on && (rx_data == on_b)) begin
                    s_d.det    = 1'b0;
                    s_d.held_v = 1'b0;
                end else if (s_q.held_off && (rx_data == off_b)) begin
                    s_d.det    = 1'b1;
                    s_d.held_v = 1'b0;
                end else begin
                    s_d.wr_en   = 1'b1;
                    s_d.wr_data = s_q.held;
                    if (first_off || first_on) begin
                        s_d.held     = rx_data;
                        s_d.held_off = first_off;
                        s_d.held_on  = first_on;
                    end else begin
                        s_d.held_v = 1'b0;
                        s_d.pend_v = 1'b1;
                        s_d.pend   = rx_data;
                    end
                end
            end else if (first_off || first_on) begin
                s_d.held_v   = 1'b1;
                s_d.held     = rx_data;
                s_d.held_off = first_off;
                s_d.held_on  = first_on;
            end else begin
                s_d.wr_en   = 1'b1;
                s_d.wr_data = rx_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_en   = s_q.wr_en;
    assign wr_data = s_q.wr_data;
    assign det     = s_q.det;

endmodule

// File: rtl/xf_tx_insert.sv
module xf_tx_insert
    import xf_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int LVL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [LVL_W-1:0]  level,
    input  logic [LVL_W-1:0]  trig,
    input  logic              det,
    input  logic              tx_busy,
    input  logic              ack,
    input  logic [CHAR_W-1:0] off_a,
    input  logic [CHAR_W-1:0] off_b,
    input  logic [CHAR_W-1:0] on_a,
    input  logic [CHAR_W-1:0] on_b,
    output logic              req,
    output logic [CHAR_W-1:0] char_o,
    output logic              halt
);

    typedef struct packed {
        ins_state_e state;
        logic       dir_off;
        logic       told_off;
        logic       above;
        logic       halt;
    } tx_state_t;

    tx_state_t s_d, s_q;
    logic      above_now;

    // Hysteresis: equal to the trigger keeps the last side.
    always_comb begin
        if (level > trig) begin
            above_now = 1'b1;
        end else if (level < trig) begin
            above_now = 1'b0;
        end else begin
            above_now = s_q.above;
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.above = above_now;

        if (mode == MODE_OFF) begin
            s_d.halt = 1'b0;
        end else if (!tx_busy) begin
            s_d.halt = det;
        end

        if (mode == MODE_OFF) begin
            s_d.state    = INS_IDLE;
            s_d.told_off = 1'b0;
        end else begin
            unique case (s_q.state)
                INS_IDLE: begin
                    if (above_now != s_q.told_off) begin
                        s_d.state   = INS_FIRST;
                        s_d.dir_off = above_now;
                    end
                end
                INS_FIRST: begin
                    if (ack) begin
                        if (mode_is_pair(mode)) begin
                            s_d.state = INS_SECOND;
                        end else begin
                            s_d.state    = INS_IDLE;
                            s_d.told_off = s_q.dir_off;
                        end
                    end
                end
                INS_SECOND: begin
                    if (ack) begin
                        s_d.state    = INS_IDLE;
                        s_d.told_off = s_q.dir_off;
                    end
                end
                default: s_d.state = INS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: INS_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        unique case (s_q.state)
            INS_FIRST:  char_o = s_q.dir_off ? off_a : on_a;
            INS_SECOND: char_o = s_q.dir_off ? off_b : on_b;
            default:    char_o = '0;
        endcase
    end

    assign req  = (s_q.state != INS_IDLE);
    assign halt = s_q.halt;

endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl
    import xf_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int LVL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [CHAR_W-1:0] cfg_wdata,
    output logic [CHAR_W-1:0] cfg_rdata,
    input  logic [1:0]        fc_mode,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              fifo_wr_en,
    output logic [CHAR_W-1:0] fifo_wr_data,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [LVL_W-1:0]  fifo_trig,
    input  logic              tx_busy,
    output logic              tx_halt,
    output logic              ins_req,
    output logic [CHAR_W-1:0] ins_char,
    input  logic              ins_ack,
    input  logic              xoff_irq_en,
    output logic              xoff_det,
    output logic              xoff_irq
);

    logic [CHAR_W-1:0] code_off_a;
    logic [CHAR_W-1:0] code_off_b;
    logic [CHAR_W-1:0] code_on_a;
    logic [CHAR_W-1:0] code_on_b;

    xf_code_regs #(.CHAR_W(CHAR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .off_a (code_off_a),
        .off_b (code_off_b),
        .on_a  (code_on_a),
        .on_b  (code_on_b)
    );

    xf_rx_match #(.CHAR_W(CHAR_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (fc_mode),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .off_a    (code_off_a),
        .off_b    (code_off_b),
        .on_a     (code_on_a),
        .on_b     (code_on_b),
        .wr_en    (fifo_wr_en),
        .wr_data  (fifo_wr_data),
        .det      (xoff_det)
    );

    xf_tx_insert #(.CHAR_W(CHAR_W), .LVL_W(LVL_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (fc_mode),
        .level   (fifo_level),
        .trig    (fifo_trig),
        .det     (xoff_det),
        .tx_busy (tx_busy),
        .ack     (ins_ack),
        .off_a   (code_off_a),
        .off_b   (code_off_b),
        .on_a    (code_on_a),
        .on_b    (code_on_b),
        .req     (ins_req),
        .char_o  (ins_char),
        .halt    (tx_halt)
    );

    assign xoff_irq = xoff_det && xoff_irq_en;

endmodule

// File: rtl/xf_checker.sv
module xf_checker #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        fc_mode,
    input logic              cfg_we,
    input logic              rx_valid,
    input logic              fifo_wr_en,
    input logic              tx_busy,
    input logic              tx_halt,
    input logic              xoff_det,
    input logic              ins_req,
    input logic              ins_ack,
    input logic [CHAR_W-1:0] ins_char
);

    AST_HALT_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && fc_mode != 2'd0) |=> $stable(tx_halt)); // R7

    AST_HALT_FROM_DET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_halt) |-> ($past(xoff_det) && !$past(tx_busy))); // R7

    AST_INS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && !ins_ack && fc_mode != 2'd0 && !cfg_we) |=> (ins_req && $stable(ins_char))); // R9

    AST_MODE_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_mode == 2'd0) |=> (!xoff_det && !tx_halt && !ins_req)); // R10

    AST_WRITE_FOLLOWS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> ($past(rx_valid) || $past(rx_valid, 2))); // R4

endmodule

bind xonxoff_flow_ctrl xf_checker #(.CHAR_W(CHAR_W)) u_xf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .fc_mode    (fc_mode),
    .cfg_we     (cfg_we),
    .rx_valid   (rx_valid),
    .fifo_wr_en (fifo_wr_en),
    .tx_busy    (tx_busy),
    .tx_halt    (tx_halt),
    .xoff_det   (xoff_det),
    .ins_req    (ins_req),
    .ins_ack    (ins_ack),
    .ins_char   (ins_char)
);

// File: tb/test_xonxoff_flow_ctrl.sv
`timescale 1ns/1ps
module test_xonxoff_flow_ctrl;

    localparam int CW = 8;
    localparam int LW = 6;
    localparam logic [7:0] C_OFF_A = 8'h13;
    localparam logic [7:0] C_OFF_B = 8'h93;
    localparam logic [7:0] C_ON_A  = 8'h11;
    localparam logic [7:0] C_ON_B  = 8'h91;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [CW-1:0] cfg_rdata;
    logic [1:0]    fc_mode = 2'd0;
    logic          rx_valid = 1'b0;
    logic [CW-1:0] rx_data = '0;
    logic          fifo_wr_en;
    logic [CW-1:0] fifo_wr_data;
    logic [LW-1:0] fifo_level = '0;
    logic [LW-1:0] fifo_trig = 6'd8;
    logic          tx_busy = 1'b0;
    logic          tx_halt;
    logic          ins_req;
    logic [CW-1:0] ins_char;
    logic          ins_ack = 1'b0;
    logic          xoff_irq_en = 1'b0;
    logic          xoff_det;
    logic          xoff_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] got_q[$];
    logic [7:0] exp_q[$];
    bit         m_det;
    bit         m_held_v, m_held_off, m_held_on;
    logic [7:0] m_held;

    always #2.5 clk = ~clk;

    xonxoff_flow_ctrl #(.CHAR_W(CW), .LVL_W(LW)) i_xonxoff_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fc_mode(fc_mode),
        .rx_valid(rx_valid), .rx_data(rx_data), .fifo_wr_en(fifo_wr_en),
        .fifo_wr_data(fifo_wr_data), .fifo_level(fifo_level), .fifo_trig(fifo_trig),
        .tx_busy(tx_busy), .tx_halt(tx_halt), .ins_req(ins_req), .ins_char(ins_char),
        .ins_ack(ins_ack), .xoff_irq_en(xoff_irq_en), .xoff_det(xoff_det),
        .xoff_irq(xoff_irq)
    );

    always @(negedge clk) begin
        if (fifo_wr_en) got_q.push_back(fifo_wr_data);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_pair();
        return fc_mode[1];
    endfunction

    // Expected-value model built from R2..R5, R10, R11.
    task automatic model_byte(input logic [7:0] b);
        bit fon, foff;
        fon  = m_det && (b == C_ON_A);
        foff = (b == C_OFF_A);
        if (fc_mode == 2'd0) begin
            exp_q.push_back(b);
        end else if (!is_pair()) begin
            m_held_v = 1'b0;
            if (fon) m_det = 1'b0;
            else if (foff) m_det = 1'b1;
            else exp_q.push_back(b);
        end else if (m_held_v) begin
            if (m_held_on && b == C_ON_B) begin
                m_det = 1'b0; m_held_v = 1'b0;
            end else if (m_held_off && b == C_OFF_B) begin
                m_det = 1'b1; m_held_v = 1'b0;
            end else begin
                exp_q.push_back(m_held);
                if (fon || foff) begin
                    m_held = b; m_held_on = fon; m_held_off = foff;
                end else begin
                    m_held_v = 1'b0;
                    exp_q.push_back(b);
                end
            end
        end else if (fon || foff) begin
            m_held_v = 1'b1; m_held = b; m_held_on = fon; m_held_off = foff;
        end else begin
            exp_q.push_back(b);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input string req);
        bit ok;
        model_byte(b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (3) @(negedge clk);
        ok = (got_q.size() == exp_q.size());
        if (ok) begin
            foreach (got_q[i]) if (got_q[i] != exp_q[i]) ok = 1'b0;
        end
        chk(ok, req, "fifo stream after byte",
            {got_q.size() > 0 ? got_q[got_q.size()-1] : 8'h00, 24'(got_q.size())},
            {exp_q.size() > 0 ? exp_q[exp_q.size()-1] : 8'h00, 24'(exp_q.size())});
        chk(xoff_det == m_det, req, "xoff_det", 32'(xoff_det), 32'(m_det));
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        fc_mode  = m;
        m_held_v = 1'b0;
        if (m == 2'd0) m_det = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ack_once();
        ins_ack = 1'b1;
        @(negedge clk);
        ins_ack = 1'b0;
    endtask

    task automatic check_ins(input bit req_e, input logic [7:0] ch_e, input string req);
        chk(ins_req == req_e, req, "ins_req", 32'(ins_req), 32'(req_e));
        if (req_e) chk(ins_char == ch_e, req, "ins_char", 32'(ins_char), 32'(ch_e));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] pool[4];
        repeat (3) @(negedge clk);
        // Reset state, R1
        for (int a = 0; a < 4; a++) begin
            cfg_addr = a[1:0];
            #0.1;
            chk(cfg_rdata == 8'h00, "R1", "reset code register", 32'(cfg_rdata), 0);
        end
        chk(!tx_halt && !ins_req && !fifo_wr_en && !xoff_det, "R6",
            "outputs idle in reset", {tx_halt, ins_req, fifo_wr_en, xoff_det}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        write_reg(2'd0, C_OFF_A);
        write_reg(2'd1, C_OFF_B);
        write_reg(2'd2, C_ON_A);
        write_reg(2'd3, C_ON_B);
        pool = '{C_OFF_A, C_OFF_B, C_ON_A, C_ON_B};
        for (int a = 0; a < 4; a++) begin
            cfg_addr = a[1:0];
            #0.1;
            chk(cfg_rdata == pool[a], "R1", "code register readback", 32'(cfg_rdata), 32'(pool[a]));
        end

        // Single mode
        set_mode(2'd1);
        xoff_irq_en = 1'b1;
        send_byte(8'h41, "R4");
        send_byte(C_ON_A, "R11");
        tx_busy = 1'b1;
        send_byte(C_OFF_A, "R2");
        chk(xoff_irq == 1'b1, "R6", "irq after stop", 32'(xoff_irq), 1);
        chk(tx_halt == 1'b0, "R7", "halt held while busy", 32'(tx_halt), 0);
        tx_busy = 1'b0;
        @(negedge clk);
        chk(tx_halt == 1'b1, "R7", "halt after busy falls", 32'(tx_halt), 1);
        xoff_irq_en = 1'b0;
        #0.1;
        chk(xoff_irq == 1'b0, "R6", "irq masked", 32'(xoff_irq), 0);
        send_byte(C_ON_A, "R6");
        chk(tx_halt == 1'b0, "R7", "halt released", 32'(tx_halt), 0);

        // Two-byte mode, directed
        set_mode(2'd2);
        send_byte(C_OFF_A, "R5");
        send_byte(8'h41, "R5");
        send_byte(C_OFF_A, "R3");
        send_byte(C_OFF_A, "R5");
        send_byte(C_OFF_B, "R3");
        chk(tx_halt == 1'b1, "R7", "halt after pair stop", 32'(tx_halt), 1);
        send_byte(C_ON_A, "R3");
        send_byte(C_ON_B, "R3");
        send_byte(C_OFF_A, "R5");
        send_byte(C_ON_A, "R11");

        // Mode off releases halt
        send_byte(C_OFF_A, "R3");
        send_byte(C_OFF_B, "R3");
        tx_busy = 1'b1;
        set_mode(2'd0);
        chk(!xoff_det && !tx_halt, "R10", "mode off clears", {xoff_det, tx_halt}, 0);
        tx_busy = 1'b0;
        send_byte(C_OFF_A, "R10");

        // Random traffic, fixed seed
        void'($urandom(32'h5eed_1234));
        set_mode(2'd2);
        for (int n = 0; n < 400; n++) begin
            logic [7:0] b;
            if (n == 200) set_mode(2'd1);
            b = ($urandom % 3 == 0) ? 8'($urandom) : pool[$urandom % 4];
            send_byte(b, fc_mode[1] ? "R3" : "R2");
        end
        send_byte(C_ON_A, "R6");
        send_byte(C_ON_B, "R6");

        // Insertion
        set_mode(2'd2);
        @(negedge clk);
        fifo_level = 6'd9;
        @(negedge clk);
        check_ins(1'b1, C_OFF_A, "R8");
        repeat (3) @(negedge clk);
        check_ins(1'b1, C_OFF_A, "R9");
        ack_once();
        check_ins(1'b1, C_OFF_B, "R9");
        ack_once();
        check_ins(1'b0, 8'h00, "R9");
        repeat (10) @(negedge clk);
        check_ins(1'b0, 8'h00, "R8");
        fifo_level = 6'd8;
        repeat (3) @(negedge clk);
        check_ins(1'b0, 8'h00, "R8");
        fifo_level = 6'd7;
        @(negedge clk);
        check_ins(1'b1, C_ON_A, "R8");
        ack_once();
        check_ins(1'b1, C_ON_B, "R9");
        ack_once();
        check_ins(1'b0, 8'h00, "R8");
        set_mode(2'd1);
        fifo_level = 6'd20;
        @(negedge clk);
        check_ins(1'b1, C_OFF_A, "R8");
        ack_once();
        check_ins(1'b0, 8'h00, "R9");
        fifo_level = 6'd0;
        @(negedge clk);
        check_ins(1'b1, C_ON_A, "R8");
        fc_mode = 2'd0;
        @(negedge clk);
        check_ins(1'b0, 8'h00, "R10");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule